// File: doc/BRIEF.md
# Multi-Source Trigger Router with Timebase Alignment

This block picks one trigger source out of several and turns it into a single-cycle trigger event on the timebase clock for an acquisition controller. The candidates are a software strobe, an external digital pin, a level crossing on one of four sampled analog channels, a star line, any one of eight shared trigger-bus lines, and an incoming synchronization-bus line. Each asynchronous line passes through a two-flop synchronizer. After that, a rising or falling edge is detected according to a polarity bit.

The analog source works on digital sample codes. It takes the top byte of the selected channel's two's-complement sample and compares it, as a signed value, against an 8-bit level. It fires when the sample crosses that level in the chosen direction.

Every accepted trigger drives two outputs toward the synchronization bus. The first is a pulse stretched to a fixed number of clocks. The second is that pulse registered once more on the timebase. Boards that take the registered copy all see the trigger on the same clock, which avoids the one-clock disagreement an unaligned line can cause. Changing the selection blocks triggers for a short window, so that switching sources does not produce a false event.

Top module: `trig_router`

## Requirements
- R1: `src_sel` picks the source: 0 software strobe, 1 external pin, 2 analog crossing, 3 star line, 4 trigger-bus line number `bus_idx`, 5 synchronization-bus input. Codes 6 and 7 never produce a trigger. Lines that are not selected have no effect.
- R2: For the digital lines, `falling_edge`=0 fires on a 0-to-1 transition and `falling_edge`=1 fires on a 1-to-0 transition. The opposite transition is ignored.
- R3: A qualifying transition on an asynchronous line, driven between two clock edges, raises `trig_event` at the third rising edge that follows.
- R4: A software strobe that is high in one cycle raises `trig_event` at the next rising edge, whatever the value of `falling_edge`.
- R5: The analog code is bits [16c+15:16c+8] of `ana_samples` for channel c = `ana_chan`, read as signed and compared with signed `ana_level`. The sample counts as "above" when code >= level. With `falling_edge`=0, a change from below to above fires. With `falling_edge`=1, a change from above to below fires. The event appears at the rising edge after the new sample is presented. Channels that are not selected are ignored.
- R6: `trig_event` is high for exactly one cycle per accepted trigger.
- R7: `sync_trig_out` rises together with `trig_event` and stays high for STRETCH (default 4) cycles. A new trigger while it is high restarts the count.
- R8: `sync_trig_reg_out` equals `sync_trig_out` delayed by one clock.
- R9: Any change of {`src_sel`, `bus_idx`, `ana_chan`} blocks triggers detected in the cycle of the change and in the two cycles after it.
- R10: In reset all outputs are low, and triggers detected in the first two cycles after reset release are blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Source select code |
| bus_idx | input | 3 | Trigger-bus line number for source 4 |
| ana_chan | input | 2 | Analog channel for source 2 |
| falling_edge | input | 1 | Edge / crossing direction (0 rising, 1 falling) |
| ana_level | input | 8 | Signed analog trigger level |
| soft_strobe | input | 1 | Synchronous software trigger strobe |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| star_in | input | 1 | Asynchronous star trigger line |
| bus_in | input | 8 | Asynchronous trigger-bus lines |
| sync_in | input | 1 | Asynchronous synchronization-bus trigger input |
| ana_samples | input | 64 | Four 16-bit two's-complement samples, channel c in bits [16c+15:16c] |
| trig_event | output | 1 | Single-cycle trigger to the acquisition controller |
| sync_trig_out | output | 1 | Stretched trigger pulse for the synchronization bus |
| sync_trig_reg_out | output | 1 | Timebase-registered copy of the stretched pulse |

## Verification
Each result has its own latency. A pin, star, bus or sync-bus transition appears on `trig_event` three rising edges after it is driven. A software strobe or a new analog sample appears after one edge. The stretched pulse starts together with the event, and its registered copy starts one edge later. The bench drives every input on the falling clock edge and samples on later falling edges. Each expected pulse is checked at exactly the cycle where it is due, and a separate check confirms that no pulse appears in any other cycle of the window. The selection-change window is checked cycle by cycle, so the first cycle in which a trigger is accepted again is pinned exactly.

// File: rtl/trig_router_pkg.sv
package trig_router_pkg;

    typedef enum logic [2:0] {
        SRC_SOFT   = 3'd0,
        SRC_PIN    = 3'd1,
        SRC_ANALOG = 3'd2,
        SRC_STAR   = 3'd3,
        SRC_BUS    = 3'd4,
        SRC_SYNC   = 3'd5
    } trig_src_e;

    // Cycles after a selection change during which triggers stay blocked
    localparam int unsigned SEL_MASK_CYCLES = 2;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

endmodule

// File: rtl/trig_level_cross.sv
module trig_level_cross #(
    parameter int NCH      = 4,
    parameter int SAMPLE_W = 16,
    parameter int LEVEL_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH*SAMPLE_W-1:0]   samples,
    input  logic [$clog2(NCH)-1:0]    chan,
    input  logic [LEVEL_W-1:0]        level,
    input  logic                      falling,
    output logic                      crossed
);

    localparam int CH_IW   = $clog2(NCH);
    localparam int TOP_OFS = SAMPLE_W - LEVEL_W;

    typedef struct packed {
        logic above;
    } cross_state_t;

    cross_state_t st_d, st_q;
    logic [LEVEL_W-1:0] code;
    logic               above_now;

    always_comb begin
        code = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan == CH_IW'(c)) code = samples[c*SAMPLE_W + TOP_OFS +: LEVEL_W];
        end
        above_now  = ($signed(code) >= $signed(level));
        st_d       = st_q;
        st_d.above = above_now;
        if (falling) crossed = st_q.above & ~above_now;
        else         crossed = above_now & ~st_q.above;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/trig_pulse_shaper.sv
module trig_pulse_shaper #(
    parameter int STRETCH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic event_out,
    output logic stretch_out,
    output logic stretch_reg_out
);

    localparam int CNT_W = $clog2(STRETCH + 1);

    typedef struct packed {
        logic             evt;
        logic [CNT_W-1:0] cnt;
        logic             t1;
        logic             t2;
    } shaper_state_t;

    shaper_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = fire;
        if (fire)             st_d.cnt = CNT_W'(STRETCH);
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        st_d.t1  = (st_d.cnt != '0);
        st_d.t2  = st_q.t1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign event_out       = st_q.evt;
    assign stretch_out     = st_q.t1;
    assign stretch_reg_out = st_q.t2;

endmodule

// File: rtl/trig_router.sv
module trig_router
    import trig_router_pkg::*;
#(
    parameter int NBUS     = 8,
    parameter int NCH      = 4,
    parameter int SAMPLE_W = 16,
    parameter int LEVEL_W  = 8,
    parameter int STRETCH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 src_sel,
    input  logic [$clog2(NBUS)-1:0]    bus_idx,
    input  logic [$clog2(NCH)-1:0]     ana_chan,
    input  logic                       falling_edge,
    input  logic [LEVEL_W-1:0]         ana_level,
    input  logic                       soft_strobe,
    input  logic                       ext_pin,
    input  logic                       star_in,
    input  logic [NBUS-1:0]            bus_in,
    input  logic                       sync_in,
    input  logic [NCH*SAMPLE_W-1:0]    ana_samples,
    output logic                       trig_event,
    output logic                       sync_trig_out,
    output logic                       sync_trig_reg_out
);

    localparam int BUS_IW   = $clog2(NBUS);
    localparam int CH_IW    = $clog2(NCH);
    localparam int NLINE    = NBUS + 3;
    localparam int LN_PIN   = 0;
    localparam int LN_STAR  = 1;
    localparam int LN_BUS0  = 2;
    localparam int LN_SYNC  = NBUS + 2;
    localparam int SEL_W    = 3 + BUS_IW + CH_IW;
    localparam int MASK_W   = $clog2(SEL_MASK_CYCLES + 1);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [MASK_W-1:0] mask;
        logic [NLINE-1:0]  prev;
    } route_state_t;

    route_state_t st_d, st_q;

    logic [NLINE-1:0] line_async, line_s;
    logic [NLINE-1:0] rise, fall, edge_v;
    logic [NBUS-1:0]  bus_edges;
    logic [SEL_W-1:0] sel_now;
    logic             ana_cross;
    logic             raw, sel_chg, fire;

    assign line_async = {sync_in, bus_in, star_in, ext_pin};

    trig_sync #(.W(NLINE)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_async),
        .sync_out (line_s)
    );

    trig_level_cross #(
        .NCH      (NCH),
        .SAMPLE_W (SAMPLE_W),
        .LEVEL_W  (LEVEL_W)
    ) u_cross (
        .clk     (clk),
        .rst_n   (rst_n),
        .samples (ana_samples),
        .chan    (ana_chan),
        .level   (ana_level),
        .falling (falling_edge),
        .crossed (ana_cross)
    );

    always_comb begin
        st_d      = st_q;
        sel_now   = {src_sel, bus_idx, ana_chan};
        rise      = line_s & ~st_q.prev;
        fall      = ~line_s & st_q.prev;
        edge_v    = falling_edge ? fall : rise;
        bus_edges = edge_v[LN_BUS0 +: NBUS];

        case (src_sel)
            SRC_SOFT:   raw = soft_strobe;
            SRC_PIN:    raw = edge_v[LN_PIN];
            SRC_ANALOG: raw = ana_cross;
            SRC_STAR:   raw = edge_v[LN_STAR];
            SRC_BUS:    raw = bus_edges[bus_idx];
            SRC_SYNC:   raw = edge_v[LN_SYNC];
            default:    raw = 1'b0;
        endcase

        sel_chg = (sel_now != st_q.sel);
        fire    = raw & ~sel_chg & (st_q.mask == '0);

        st_d.prev = line_s;
        st_d.sel  = sel_now;
        if (sel_chg)              st_d.mask = MASK_W'(SEL_MASK_CYCLES);
        else if (st_q.mask != '0) st_d.mask = st_q.mask - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= '0;
            st_q.mask <= MASK_W'(SEL_MASK_CYCLES);
            st_q.prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    trig_pulse_shaper #(.STRETCH(STRETCH)) u_shape (
        .clk             (clk),
        .rst_n           (rst_n),
        .fire            (fire),
        .event_out       (trig_event),
        .stretch_out     (sync_trig_out),
        .stretch_reg_out (sync_trig_reg_out)
    );

endmodule

// File: rtl/trig_router_chk.sv
module trig_router_chk #(
    parameter int NBUS    = 8,
    parameter int NCH     = 4,
    parameter int STRETCH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              src_sel,
    input logic [$clog2(NBUS)-1:0] bus_idx,
    input logic [$clog2(NCH)-1:0]  ana_chan,
    input logic                    trig_event,
    input logic                    sync_trig_out,
    input logic                    sync_trig_reg_out
);

    localparam int SEL_W = 3 + $clog2(NBUS) + $clog2(NCH);

    logic [SEL_W-1:0] sel;
    logic [7:0]       hi_cnt;

    assign sel = {src_sel, bus_idx, ana_chan};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            hi_cnt <= '0;
        else if (!sync_trig_out)               hi_cnt <= '0;
        else if (hi_cnt != 8'hFF)              hi_cnt <= hi_cnt + 8'd1;
    end

    p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel > 3'd5) |=> !trig_event);

    p_event_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_event |-> sync_trig_out);

    p_rise_needs_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_trig_out) |-> trig_event);

    p_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_trig_out) |-> (hi_cnt >= 8'(STRETCH)));

    p_reg_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_trig_reg_out == $past(sync_trig_out));

    p_sel_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |=> !trig_event ##1 !trig_event ##1 !trig_event);

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!trig_event && !sync_trig_out && !sync_trig_reg_out));

endmodule

bind trig_router trig_router_chk #(
    .NBUS    (NBUS),
    .NCH     (NCH),
    .STRETCH (STRETCH)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .src_sel           (src_sel),
    .bus_idx           (bus_idx),
    .ana_chan          (ana_chan),
    .trig_event        (trig_event),
    .sync_trig_out     (sync_trig_out),
    .sync_trig_reg_out (sync_trig_reg_out)
);

// File: tb/tb_trig_router.sv
`timescale 1ns/1ps
module tb_trig_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_sel = 3'd0;
    logic [2:0]  bus_idx = 3'd0;
    logic [1:0]  ana_chan = 2'd0;
    logic        falling_edge = 1'b0;
    logic [7:0]  ana_level = 8'h00;
    logic        soft_strobe = 1'b0;
    logic        ext_pin = 1'b0;
    logic        star_in = 1'b0;
    logic [7:0]  bus_in = 8'h00;
    logic        sync_in = 1'b0;
    logic [63:0] ana_samples = '0;
    logic        trig_event, sync_trig_out, sync_trig_reg_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_router dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .src_sel           (src_sel),
        .bus_idx           (bus_idx),
        .ana_chan          (ana_chan),
        .falling_edge      (falling_edge),
        .ana_level         (ana_level),
        .soft_strobe       (soft_strobe),
        .ext_pin           (ext_pin),
        .star_in           (star_in),
        .bus_in            (bus_in),
        .sync_in           (sync_in),
        .ana_samples       (ana_samples),
        .trig_event        (trig_event),
        .sync_trig_out     (sync_trig_out),
        .sync_trig_reg_out (sync_trig_reg_out)
    );

    // {src[3], idx[3], pol, line[4], dir, expect, pad[3]}
    // line: 0 pin, 1 star, 2..9 bus0..7, 10 sync input, 11 software strobe
    localparam int NVEC = 13;
    localparam logic [15:0] VEC [NVEC] = '{
        {3'd0, 3'd0, 1'b0, 4'd11, 1'b1, 1'b1, 3'd0},
        {3'd0, 3'd0, 1'b1, 4'd11, 1'b1, 1'b1, 3'd0},
        {3'd1, 3'd0, 1'b0, 4'd0,  1'b1, 1'b1, 3'd0},
        {3'd1, 3'd0, 1'b0, 4'd0,  1'b0, 1'b0, 3'd0},
        {3'd1, 3'd0, 1'b1, 4'd0,  1'b0, 1'b1, 3'd0},
        {3'd3, 3'd0, 1'b0, 4'd1,  1'b1, 1'b1, 3'd0},
        {3'd3, 3'd0, 1'b1, 4'd1,  1'b1, 1'b0, 3'd0},
        {3'd4, 3'd3, 1'b0, 4'd5,  1'b1, 1'b1, 3'd0},
        {3'd4, 3'd3, 1'b0, 4'd6,  1'b1, 1'b0, 3'd0},
        {3'd4, 3'd7, 1'b1, 4'd9,  1'b0, 1'b1, 3'd0},
        {3'd5, 3'd0, 1'b0, 4'd10, 1'b1, 1'b1, 3'd0},
        {3'd6, 3'd0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd0},
        {3'd1, 3'd0, 1'b0, 4'd1,  1'b1, 1'b0, 3'd0}
    };

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(int l, logic v);
        if (l == 0)                 ext_pin = v;
        else if (l == 1)            star_in = v;
        else if (l >= 2 && l <= 9)  bus_in[l-2] = v;
        else if (l == 10)           sync_in = v;
    endtask

    task automatic set_ch(int c, logic [15:0] v);
        ana_samples[c*16 +: 16] = v;
    endtask

    // expect a single event exactly one edge after the stimulus, none otherwise
    task automatic expect_one_edge(string req, logic exp);
        logic stray;
        stray = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) chk(req, trig_event, exp);
            else if (trig_event) stray = 1'b1;
        end
        chk(req, stray, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] v;
        int line, lat;
        logic ex, stray;

        // R10: reset state and post-reset blocking
        wait_n(3);
        chk("R10 reset trig_event", trig_event, 1'b0);
        chk("R10 reset sync_trig_out", sync_trig_out, 1'b0);
        chk("R10 reset sync_trig_reg_out", sync_trig_reg_out, 1'b0);
        rst_n = 1'b1;
        soft_strobe = 1'b1;
        @(negedge clk); chk("R10 blocked cycle 1", trig_event, 1'b0);
        @(negedge clk); chk("R10 blocked cycle 2", trig_event, 1'b0);
        @(negedge clk); chk("R10 first accepted", trig_event, 1'b1);
        soft_strobe = 1'b0;
        wait_n(8);

        // Table walk: R1 R2 R3 R4 R6
        for (int i = 0; i < NVEC; i++) begin
            v    = VEC[i];
            line = int'(v[8:5]);
            ex   = v[3];
            if (line != 11) set_line(line, ~v[4]);
            wait_n(6);
            src_sel      = v[15:13];
            bus_idx      = v[12:10];
            falling_edge = v[9];
            wait_n(5);
            lat = (line == 11) ? 1 : 3;
            if (line == 11) soft_strobe = 1'b1;
            else            set_line(line, v[4]);
            stray = 1'b0;
            for (int k = 1; k <= 6; k++) begin
                @(negedge clk);
                soft_strobe = 1'b0;
                if (k == lat) chk($sformatf("R1 R2 R3 R4 vector %0d", i), trig_event, ex);
                else if (trig_event) stray = 1'b1;
            end
            chk($sformatf("R6 single pulse vector %0d", i), stray, 1'b0);
        end

        // R7 R8: stretch width and registered copy
        src_sel = 3'd0; bus_idx = 3'd0; falling_edge = 1'b0;
        wait_n(8);
        soft_strobe = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            soft_strobe = 1'b0;
            chk($sformatf("R7 stretch k=%0d", k), sync_trig_out, (k >= 1 && k <= 4));
            chk($sformatf("R8 registered k=%0d", k), sync_trig_reg_out, (k >= 2 && k <= 5));
        end
        wait_n(6);
        // R7 retrigger restarts the count
        soft_strobe = 1'b1;
        @(negedge clk); soft_strobe = 1'b0;
        @(negedge clk); soft_strobe = 1'b1;
        @(negedge clk); soft_strobe = 1'b0;
        wait_n(3);
        chk("R7 retrigger still high", sync_trig_out, 1'b1);
        @(negedge clk);
        chk("R7 retrigger ends", sync_trig_out, 1'b0);
        wait_n(6);

        // R9: selection change blocks three detection cycles
        bus_idx = 3'd5;
        soft_strobe = 1'b1;
        @(negedge clk); chk("R9 change cycle", trig_event, 1'b0);
        @(negedge clk); chk("R9 mask cycle 1", trig_event, 1'b0);
        @(negedge clk); chk("R9 mask cycle 2", trig_event, 1'b0);
        @(negedge clk); chk("R9 first accepted", trig_event, 1'b1);
        soft_strobe = 1'b0;
        wait_n(8);

        // R5: analog crossing
        for (int c = 0; c < 4; c++) set_ch(c, 16'h0500);
        ana_level = 8'h10; ana_chan = 2'd2; src_sel = 3'd2; falling_edge = 1'b0;
        wait_n(8);
        set_ch(1, 16'h7F00);
        expect_one_edge("R5 other channel ignored", 1'b0);
        set_ch(2, 16'h1000);
        expect_one_edge("R5 rising at equal level", 1'b1);
        set_ch(2, 16'h0F00);
        expect_one_edge("R5 falling ignored when rising set", 1'b0);
        set_ch(2, 16'h1000);
        expect_one_edge("R5 rising again", 1'b1);
        falling_edge = 1'b1;
        wait_n(4);
        set_ch(2, 16'h0F00);
        expect_one_edge("R5 falling crossing", 1'b1);
        falling_edge = 1'b0;
        ana_level = 8'h00;
        set_ch(2, 16'hFF00);
        wait_n(6);
        set_ch(2, 16'h0100);
        expect_one_edge("R5 signed compare -1 to +1", 1'b1);

        wait_n(4);
        summary();
    end

endmodule